// File: doc/BRIEF.md
# Filtered Traffic Byte Counter with Threshold Interrupt

This block watches a simple transaction-observation port and accumulates the byte size of every transaction that passes an ID filter. Each observed beat carries a valid strobe, a byte count and a requester ID. A beat is accepted only when the monitor is running and the ID, ANDed with a programmable mask, equals a programmable match value.

Software programs a limit. When an accepted beat brings the running total to or above that limit, a sticky threshold-hit flag is raised. When the sum no longer fits in the counter, a separate sticky overflow flag is raised. A build-time option makes the counter subtract the limit each time the limit is reached, so the total restarts from zero. Because the hit flag is still raised, software can rebuild the true total by adding the limit back. One interrupt-enable bit gates the flags onto a single interrupt line.

Registers sit behind a one-cycle register port. Word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | counter clear | write only |
| 2 | count | read only |
| 3 | limit | read/write |
| 4 | ID mask | read/write |
| 5 | ID match | read/write |
| 6 | flags | read only |
| 7 | flag clear | write only |
| 8 | interrupt enable | read/write |

Reads are combinational from the addressed register. Write-only and unused addresses read as zero.

Top module: `traffic_byte_monitor`

## Requirements
- R1: After reset the count, the flags, the control word, the mask, the match value and the interrupt enable are all 0, the limit reads all ones, and `irq` is low.
- R2: While control bit 0 (run) is 1, each beat with `obs_valid` high that passes the filter adds `obs_bytes` to the count at the next clock edge. Beats with `obs_valid` low are ignored.
- R3: A beat passes the filter only when (`obs_id` AND mask) equals match. A mask of 0 with a match of 0 passes every ID.
- R4: While run is 0, no beat changes the count and no flag is set. The count and the flags keep their values.
- R5: Flag bit 0 (threshold hit) is set by an accepted beat whose count-plus-bytes sum is greater than or equal to the limit.
- R6: Flag bit 1 (overflow) is set by an accepted beat whose resulting value does not fit in CNT_W bits. The count keeps the low CNT_W bits.
- R7: With WRAP_AT_LIMIT = 1, an accepted beat whose sum reaches the limit stores the sum minus the limit, and still sets flag bit 0.
- R8: Writing a value with bit 0 set to the counter-clear address zeroes the count. An accepted beat in the same cycle is dropped and sets no flag.
- R9: Writing to the flag-clear address clears each flag whose data bit is 1 and leaves the other flags unchanged. A flag being set in the same cycle as its clear stays set.
- R10: `irq` is high exactly when interrupt-enable bit 0 is 1 and any flag is set. Flags are captured even while the interrupt is disabled.
- R11: Control bits 20:16 hold a 5-bit throttle-adjust value that reads back as written and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obs_valid | input | 1 | Observed transaction strobe |
| obs_bytes | input | BYTES_W | Byte size of the observed transaction |
| obs_id | input | ID_W | Requester ID of the observed transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt: enabled OR of the flags |

## Verification
Two functions can fall in the same clock cycle. A counter-clear write can arrive together with an accepted beat, and a flag-clear write can arrive together with a beat that sets that flag. The bench provokes both by driving the register write and the observed beat in one cycle. It judges the result by reading back a zero count with no flag in the first case, and a flag that is still set, with `irq` high, in the second. Wrap and overflow are judged on narrow-counter instances, so the expected remainders (20, 0 and 6) can be reached in a few beats.

// File: rtl/traffic_byte_monitor.sv
module traffic_byte_monitor #(
  parameter int CNT_W         = 32,
  parameter int BYTES_W       = 8,
  parameter int ID_W          = 8,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter bit WRAP_AT_LIMIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [BYTES_W-1:0] obs_bytes,
  input  logic [ID_W-1:0]   obs_id,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_FCLR  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(8);
  localparam int TADJ_LSB = 16;
  localparam int TADJ_W   = 5;
  localparam int SUM_W    = CNT_W + 1;

  logic              run_q;
  logic [TADJ_W-1:0] tadj_q;
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  limit_q;
  logic [ID_W-1:0]   mask_q;
  logic [ID_W-1:0]   match_q;
  logic [1:0]        status_q;
  logic              inten_q;

  logic clr_cnt, take, hit, ovf;
  logic [1:0] fclr_bits;
  logic [SUM_W-1:0] sum, nxt;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign clr_cnt   = reg_wr && reg_addr == A_CLEAR && reg_wdata[0];
  assign fclr_bits = (reg_wr && reg_addr == A_FCLR) ? reg_wdata[1:0] : 2'b00;
  assign take      = run_q && obs_valid && ((obs_id & mask_q) == match_q) && !clr_cnt;
  assign sum       = {1'b0, count_q} + SUM_W'(obs_bytes);
  assign hit       = sum >= {1'b0, limit_q};

  generate
    if (WRAP_AT_LIMIT) begin : g_wrap
      assign nxt = hit ? sum - {1'b0, limit_q} : sum;
    end else begin : g_hold
      assign nxt = sum;
    end
  endgenerate

  assign ovf = nxt[CNT_W];
  assign irq = inten_q && (status_q != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      tadj_q   <= '0;
      count_q  <= '0;
      limit_q  <= '1;
      mask_q   <= '0;
      match_q  <= '0;
      status_q <= 2'b00;
      inten_q  <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            run_q  <= reg_wdata[0];
            tadj_q <= reg_wdata[TADJ_LSB +: TADJ_W];
          end
          A_LIMIT: limit_q <= reg_wdata[CNT_W-1:0];
          A_MASK:  mask_q  <= reg_wdata[ID_W-1:0];
          A_MATCH: match_q <= reg_wdata[ID_W-1:0];
          A_IEN:   inten_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (clr_cnt) count_q <= '0;
      else if (take) count_q <= nxt[CNT_W-1:0];
      status_q <= (status_q & ~fclr_bits) | {take && ovf, take && hit};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0] = run_q;
        reg_rdata[TADJ_LSB +: TADJ_W] = tadj_q;
      end
      A_COUNT: reg_rdata = DATA_W'(count_q);
      A_LIMIT: reg_rdata = DATA_W'(limit_q);
      A_MASK:  reg_rdata = DATA_W'(mask_q);
      A_MATCH: reg_rdata = DATA_W'(match_q);
      A_FLAGS: reg_rdata = DATA_W'(status_q);
      A_IEN:   reg_rdata = DATA_W'(inten_q);
      default: reg_rdata = '0;
    endcase
  end

endmodule

module traffic_byte_monitor_chk #(
  parameter int CNT_W  = 32,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              obs_valid,
  input logic [ID_W-1:0]   obs_id,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              run_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [ID_W-1:0]   mask_q,
  input logic [ID_W-1:0]   match_q,
  input logic [1:0]        status_q
);

  logic cnt_clr_w, fclr0_w, fclr1_w;
  assign cnt_clr_w = reg_wr && reg_addr == ADDR_W'(1) && reg_wdata[0];
  assign fclr0_w   = reg_wr && reg_addr == ADDR_W'(7) && reg_wdata[0];
  assign fclr1_w   = reg_wr && reg_addr == ADDR_W'(7) && reg_wdata[1];

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!obs_valid && !cnt_clr_w) |=> $stable(count_q));

  assert_filter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && ((obs_id & mask_q) != match_q) && !cnt_clr_w) |=> $stable(count_q));

  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_clr_w) |=> $stable(count_q));

  assert_no_flag_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> ((status_q & ~$past(status_q)) == 2'b00));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] && !fclr1_w) |=> status_q[1]);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_w |=> (count_q == '0));

  assert_hit_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !fclr0_w) |=> status_q[0]);

endmodule

bind traffic_byte_monitor traffic_byte_monitor_chk #(
  .CNT_W(CNT_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_id(obs_id),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .run_q(run_q), .count_q(count_q), .mask_q(mask_q), .match_q(match_q),
  .status_q(status_q)
);

// File: tb/traffic_byte_monitor_bench.sv
module traffic_byte_monitor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obs_valid = 1'b0;
  logic [7:0] obs_bytes = '0;
  logic [7:0] obs_id = '0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_m, rd_w, rd_s;
  logic irq_m, irq_w, irq_s;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  traffic_byte_monitor u_traffic_byte_monitor (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_bytes(obs_bytes),
    .obs_id(obs_id), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_m), .irq(irq_m));

  traffic_byte_monitor #(.CNT_W(10), .WRAP_AT_LIMIT(1'b1)) u_wrap (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_bytes(obs_bytes),
    .obs_id(obs_id), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_w), .irq(irq_w));

  traffic_byte_monitor #(.CNT_W(10)) u_small (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_bytes(obs_bytes),
    .obs_id(obs_id), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_s), .irq(irq_s));

  // {id, bytes, valid, expected count}; filter mask 0xF0, match 0x30
  localparam logic [48:0] VEC [8] = '{
    {8'h31, 8'd10,  1'b1, 32'd10},
    {8'h35, 8'd20,  1'b0, 32'd10},
    {8'h41, 8'd50,  1'b1, 32'd10},
    {8'h3F, 8'd255, 1'b1, 32'd265},
    {8'h30, 8'd1,   1'b1, 32'd266},
    {8'h00, 8'd7,   1'b1, 32'd266},
    {8'hB3, 8'd9,   1'b1, 32'd266},
    {8'h30, 8'd0,   1'b1, 32'd266}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic beat(input logic [7:0] id, input logic [7:0] b, input logic v);
    @(negedge clk);
    obs_valid = v; obs_id = id; obs_bytes = b;
    @(negedge clk);
    obs_valid = 1'b0;
  endtask

  task automatic both(input logic [7:0] b, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    obs_valid = 1'b1; obs_id = 8'h30; obs_bytes = b;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    obs_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd2); check("R1 count", rd_m, 0);
    rd(4'd6); check("R1 flags", rd_m, 0);
    rd(4'd0); check("R1 control", rd_m, 0);
    rd(4'd3); check("R1 limit", rd_m, 32'hFFFF_FFFF);
    rd(4'd4); check("R1 mask", rd_m, 0);
    check("R1 irq", {31'd0, irq_m}, 0);

    wr(4'd4, 32'hF0);
    wr(4'd5, 32'h30);
    wr(4'd0, 32'h001F_0001);
    rd(4'd0); check("R11 throttle readback", rd_m, 32'h001F_0001);

    for (int i = 0; i < 8; i++) begin
      beat(VEC[i][48:41], VEC[i][40:33], VEC[i][32]);
      rd(4'd2);
      check($sformatf("R2/R3 vector %0d count", i), rd_m, VEC[i][31:0]);
    end
    rd(4'd6); check("R5 no hit below limit", rd_m, 0);

    wr(4'd0, 32'h0);
    beat(8'h30, 8'd5, 1'b1);
    rd(4'd2); check("R4 count held while off", rd_m, 266);
    rd(4'd6); check("R4 no flag while off", rd_m, 0);
    wr(4'd0, 32'h001F_0001);

    wr(4'd1, 32'h1);
    wr(4'd3, 32'd100);
    beat(8'h30, 8'd60, 1'b1);
    rd(4'd6); check("R5 below limit", rd_m, 0);
    beat(8'h30, 8'd40, 1'b1);
    rd(4'd2); check("R5 count at limit", rd_m, 100);
    rd(4'd6); check("R5 hit flag", rd_m, 1);
    check("R10 irq off while disabled", {31'd0, irq_m}, 0);
    wr(4'd8, 32'h1);
    rd(4'd6); check("R10 irq on", {31'd0, irq_m}, 1);
    wr(4'd7, 32'h1);
    rd(4'd6); check("R9 flag cleared", rd_m, 0);
    check("R10 irq drops", {31'd0, irq_m}, 0);

    both(8'd7, 4'd1, 32'h1);
    rd(4'd2); check("R8 clear wins count", rd_m, 0);
    rd(4'd6); check("R8 dropped beat no flag", rd_m, 0);

    both(8'd150, 4'd7, 32'h1);
    rd(4'd6); check("R9 set wins over clear", rd_m, 1);
    check("R9 irq with flag kept", {31'd0, irq_m}, 1);
    wr(4'd7, 32'h3);

    wr(4'd1, 32'h1);
    beat(8'h30, 8'd60, 1'b1);
    beat(8'h30, 8'd60, 1'b1);
    rd(4'd2); check("R7 wrap remainder", rd_w, 20);
    rd(4'd6); check("R7 wrap hit flag", rd_w, 1);
    wr(4'd7, 32'h1);
    beat(8'h30, 8'd80, 1'b1);
    rd(4'd2); check("R7 wrap exact to zero", rd_w, 0);
    rd(4'd6); check("R7 wrap exact hit", rd_w, 1);

    wr(4'd1, 32'h1);
    wr(4'd7, 32'h3);
    wr(4'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) beat(8'h30, 8'd255, 1'b1);
    rd(4'd2); check("R6 narrow count before wrap", rd_s, 1020);
    rd(4'd6); check("R6 no flag before wrap", rd_s, 0);
    beat(8'h30, 8'd10, 1'b1);
    rd(4'd2); check("R6 low bits kept", rd_s, 6);
    rd(4'd6); check("R6 overflow and hit flags", rd_s, 3);
    wr(4'd7, 32'h2);
    rd(4'd6); check("R9 per-bit clear", rd_s, 1);
    rd(4'd2); check("R2 wide count no overflow", rd_m, 1030);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule